// File: doc/BRIEF.md
# Host-to-Device Register Frame Encoder

The encoder turns a disk transfer request into the 20-byte register frame that a host sends to a drive to start a command. A request carries a start sector, a block count, a direction, a queued-command flag, a command slot number and a port multiplier number. The block decides whether the short (28-bit) or the extended (48-bit) addressing form is needed and picks the matching opcode. The opcodes are parameters. For queued commands it moves the block count into the features field and places the slot tag in the count field.

The finished frame leaves as five 32-bit words with a valid/ready handshake. The lowest-addressed byte of each word sits in bits 7:0. While a frame is in flight, no new request is taken. A request that needs the extended form for a drive not marked as supporting it is refused. The refusal is a one-cycle pulse, and no words are sent for that request.

Top module: `h2d_frame_encoder`

## Requirements
- R1: After an accepted, encodable request, exactly five words are presented. `reqReady` then returns high.
- R2: Word 0 has byte 0 = 0x27, byte 1 = 0x80 | pmp[3:0], byte 2 = the chosen opcode and byte 3 = features[7:0]. Words use byte n of the frame at bits 8*(n mod 4)+7 : 8*(n mod 4) of word n/4.
- R3: The extended form is used when any sector bit at or above bit 28 is set, when the count is above 256, or when the queued flag is set. Otherwise the short form is used.
- R4: Short form: the opcode is 0xC8 for reads and 0xCA for writes, and features are 0. The device byte is 0x40 | sector[27:24]. Bytes 4..6 hold sector[23:0] and bytes 8..10 are zero. Byte 12 holds count[7:0] and byte 13 is zero, so a count of 256 encodes as 0.
- R5: Extended, unqueued form: the opcode is 0x25 for reads and 0x35 for writes, and features are 0. The device byte is 0x40. Bytes 4..6 and 8..10 hold sector[47:0] low byte first, and bytes 12..13 hold count[15:0].
- R6: Queued form: the opcode is 0x60 for reads and 0x61 for writes. Features bytes 3 and 11 hold the block count. Count bytes 12..13 hold slot << 3. The device byte is 0x40 for reads and 0xC0 (force unit access) for writes.
- R7: Bytes 14..19 of the frame are always zero.
- R8: When the extended form is needed and `devLong` is low, `errPulse` is high for one cycle in the cycle after acceptance, and no frame word is presented for that request.
- R9: While `wordValid` is high and `wordReady` is low, `wordData` and `wordLast` hold their values.
- R10: `reqReady` stays low from acceptance until the fifth word has been taken. `wordLast` is high only on the fifth word.
- R11: After reset, `reqReady` is high and `wordValid` and `errPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Encoder can take a request |
| reqLba | input | 48 | Start sector |
| reqCount | input | 16 | Block count |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqQueued | input | 1 | Queued (tagged) command |
| reqSlot | input | 5 | Command slot, used as tag |
| reqPmp | input | 4 | Port multiplier number |
| devLong | input | 1 | Drive supports 48-bit addressing |
| wordValid | output | 1 | Frame word present |
| wordReady | input | 1 | Consumer takes the word |
| wordData | output | 32 | Frame word, low byte first |
| wordLast | output | 1 | Fifth word of the frame |
| errPulse | output | 1 | Request refused (address limit) |

## Verification
The embedded properties check the following on every cycle:
- the handshake: words hold while stalled, a frame continues after each non-final word, and the encoder is ready again after the last word;
- that a refusal pulse follows only a request that was refused, and never overlaps a word.

The frame contents need the bench's scenarios. These are the choice of form at the sector-bit-28 and count-256 boundaries, the device-byte nibble, count truncation to 8 bits, queued field remapping, the write force-unit-access bit, and refusals for each reason. The bench's reference model recomputes every word from the request and compares it while the consumer stalls at random.

// File: rtl/h2dFramePkg.sv
package h2dFramePkg;
  localparam int FRAME_WORDS = 5;
  localparam int IDX_W = 3;
  localparam int LBA_W = 48;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] wordIdx;
  } frameCtl_t;
endpackage

// File: rtl/h2d_frame_datapath.sv
module h2d_frame_datapath
  import h2dFramePkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int PMP_W = 4,
  parameter logic [7:0] OP_RD_SHORT = 8'hC8,
  parameter logic [7:0] OP_WR_SHORT = 8'hCA,
  parameter logic [7:0] OP_RD_LONG = 8'h25,
  parameter logic [7:0] OP_WR_LONG = 8'h35,
  parameter logic [7:0] OP_RD_QUEUED = 8'h60,
  parameter logic [7:0] OP_WR_QUEUED = 8'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LBA_W-1:0]  reqLba,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqWrite,
  input  logic              reqQueued,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [PMP_W-1:0]  reqPmp,
  input  logic              devLong,
  input  frameCtl_t         ctl,
  output logic              needsRefusal,
  output logic [31:0]       wordData
);
  localparam int SHORT_BITS = 28;
  localparam logic [CNT_W-1:0] SHORT_CNT_MAX = CNT_W'(256);
  localparam logic [7:0] FRAME_TYPE = 8'h27;
  localparam logic [7:0] DEV_LBA = 8'h40;
  localparam logic [7:0] DEV_FUA = 8'hC0;

  logic             longForm;
  logic [7:0]       opNext, devNext;
  logic [15:0]      featNext, cntNext;
  logic [LBA_W-1:0] lbaNext;

  logic [7:0]       pmpQ, opQ, devQ;
  logic [15:0]      featQ, cntQ;
  logic [LBA_W-1:0] lbaQ;

  assign longForm = (|reqLba[LBA_W-1:SHORT_BITS]) || (reqCount > SHORT_CNT_MAX) || reqQueued;
  assign needsRefusal = longForm && !devLong;

  always_comb begin
    if (!longForm) begin
      opNext   = reqWrite ? OP_WR_SHORT : OP_RD_SHORT;
      featNext = '0;
      devNext  = DEV_LBA | {4'h0, reqLba[27:24]};
      lbaNext  = {{(LBA_W-24){1'b0}}, reqLba[23:0]};
      cntNext  = {8'h00, reqCount[7:0]};
    end else if (reqQueued) begin
      opNext   = reqWrite ? OP_WR_QUEUED : OP_RD_QUEUED;
      featNext = reqCount;
      devNext  = reqWrite ? DEV_FUA : DEV_LBA;
      lbaNext  = reqLba;
      cntNext  = 16'({reqSlot, 3'b000});
    end else begin
      opNext   = reqWrite ? OP_WR_LONG : OP_RD_LONG;
      featNext = '0;
      devNext  = DEV_LBA;
      lbaNext  = reqLba;
      cntNext  = reqCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmpQ  <= '0;
      opQ   <= '0;
      devQ  <= '0;
      featQ <= '0;
      cntQ  <= '0;
      lbaQ  <= '0;
    end else if (ctl.capture) begin
      pmpQ  <= 8'h80 | 8'(reqPmp);
      opQ   <= opNext;
      devQ  <= devNext;
      featQ <= featNext;
      cntQ  <= cntNext;
      lbaQ  <= lbaNext;
    end
  end

  always_comb begin
    case (ctl.wordIdx)
      3'd0:    wordData = {featQ[7:0], opQ, pmpQ, FRAME_TYPE};
      3'd1:    wordData = {devQ, lbaQ[23:0]};
      3'd2:    wordData = {featQ[15:8], lbaQ[47:24]};
      3'd3:    wordData = {16'h0000, cntQ};
      default: wordData = '0;
    endcase
  end
endmodule

// File: rtl/h2d_frame_control.sv
module h2d_frame_control
  import h2dFramePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      needsRefusal,
  input  logic      wordReady,
  output logic      reqReady,
  output logic      wordValid,
  output logic      wordLast,
  output logic      errPulse,
  output frameCtl_t ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;
  state_t           state;
  logic [IDX_W-1:0] idxQ;
  logic             accept;

  assign reqReady    = (state == ST_IDLE);
  assign accept      = reqValid && reqReady;
  assign wordValid   = (state == ST_SEND);
  assign wordLast    = wordValid && (idxQ == LAST_IDX);
  assign ctl.capture = accept && !needsRefusal;
  assign ctl.wordIdx = idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idxQ     <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && needsRefusal;
      if (ctl.capture) begin
        state <= ST_SEND;
        idxQ  <= '0;
      end else if (wordValid && wordReady) begin
        if (idxQ == LAST_IDX) begin
          state <= ST_IDLE;
          idxQ  <= '0;
        end else begin
          idxQ <= idxQ + 1'b1;
        end
      end
    end
  end

  // R1: a frame does not end before its last word
  a_r1_frame_continues: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady && !wordLast) |=> wordValid);
  // R10: the encoder is ready again right after the last word
  a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady && wordLast) |=> (reqReady && !wordValid));
  // R8: a refusal follows only a refused request
  a_r8_err_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errPulse) |-> $past(reqValid && needsRefusal));
  // R8: no frame word while refusing
  a_r8_err_no_words: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !wordValid);
  // R9: a stalled word stays presented
  a_r9_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(idxQ)));
endmodule

// File: rtl/h2d_frame_encoder.sv
module h2d_frame_encoder
  import h2dFramePkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int PMP_W = 4,
  parameter logic [7:0] OP_RD_SHORT = 8'hC8,
  parameter logic [7:0] OP_WR_SHORT = 8'hCA,
  parameter logic [7:0] OP_RD_LONG = 8'h25,
  parameter logic [7:0] OP_WR_LONG = 8'h35,
  parameter logic [7:0] OP_RD_QUEUED = 8'h60,
  parameter logic [7:0] OP_WR_QUEUED = 8'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LBA_W-1:0]  reqLba,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqWrite,
  input  logic              reqQueued,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [PMP_W-1:0]  reqPmp,
  input  logic              devLong,
  output logic              wordValid,
  input  logic              wordReady,
  output logic [31:0]       wordData,
  output logic              wordLast,
  output logic              errPulse
);
  frameCtl_t ctl;
  logic      needsRefusal;

  h2d_frame_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needsRefusal(needsRefusal),
    .wordReady(wordReady), .reqReady(reqReady), .wordValid(wordValid),
    .wordLast(wordLast), .errPulse(errPulse), .ctl(ctl)
  );

  h2d_frame_datapath #(
    .SLOT_W(SLOT_W), .PMP_W(PMP_W),
    .OP_RD_SHORT(OP_RD_SHORT), .OP_WR_SHORT(OP_WR_SHORT),
    .OP_RD_LONG(OP_RD_LONG), .OP_WR_LONG(OP_WR_LONG),
    .OP_RD_QUEUED(OP_RD_QUEUED), .OP_WR_QUEUED(OP_WR_QUEUED)
  ) u_data (
    .clk(clk), .rstN(rstN), .reqLba(reqLba), .reqCount(reqCount),
    .reqWrite(reqWrite), .reqQueued(reqQueued), .reqSlot(reqSlot),
    .reqPmp(reqPmp), .devLong(devLong), .ctl(ctl),
    .needsRefusal(needsRefusal), .wordData(wordData)
  );

  // R9: a stalled word keeps its content
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> ($stable(wordData) && $stable(wordLast)));
endmodule

// File: tb/sim_h2d_frame_encoder.sv
`timescale 1ns/1ps
module sim_h2d_frame_encoder;
  localparam int NREQ = 12;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite, reqQueued, devLong;
  logic [47:0] reqLba;
  logic [15:0] reqCount;
  logic [4:0]  reqSlot;
  logic [3:0]  reqPmp;
  logic        wordValid, wordReady, wordLast, errPulse;
  logic [31:0] wordData;

  always #5 clk = ~clk;

  h2d_frame_encoder u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLba(reqLba), .reqCount(reqCount), .reqWrite(reqWrite),
    .reqQueued(reqQueued), .reqSlot(reqSlot), .reqPmp(reqPmp),
    .devLong(devLong), .wordValid(wordValid), .wordReady(wordReady),
    .wordData(wordData), .wordLast(wordLast), .errPulse(errPulse)
  );

  int compared = 0;
  int mismatched = 0;

  logic [47:0] tLba[NREQ];
  logic [15:0] tCnt[NREQ];
  logic        tWr[NREQ], tQ[NREQ], tCap[NREQ];
  logic [4:0]  tSlot[NREQ];
  logic [3:0]  tPmp[NREQ];

  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          busy = 0;
  bit          errPend = 0;
  bit          stalledPrev = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReq(input int i, input logic [47:0] lba, input logic [15:0] cnt,
                        input logic wr, input logic q, input logic [4:0] slot,
                        input logic [3:0] pmp, input logic cap);
    tLba[i] = lba; tCnt[i] = cnt; tWr[i] = wr; tQ[i] = q;
    tSlot[i] = slot; tPmp[i] = pmp; tCap[i] = cap;
  endtask

  // Reference model: returns 1 when the request must be refused, else queues five words
  function automatic bit modelRequest(input int i);
    logic [7:0]  b[20];
    bit          isLong;
    string       modeTag;
    logic [15:0] feat, cnt;
    logic [47:0] lba;
    logic [7:0]  op, dev;
    isLong = (tLba[i] >= 48'h0000_1000_0000) || (tCnt[i] > 16'd256) || tQ[i]; // R3
    if (isLong && !tCap[i]) return 1'b1;                                      // R8
    if (!isLong) begin
      modeTag = "R4"; op = tWr[i] ? 8'hCA : 8'hC8; feat = 0;
      dev = 8'h40 + {4'h0, tLba[i][27:24]};
      lba = {24'h0, tLba[i][23:0]}; cnt = {8'h0, tCnt[i][7:0]};
    end else if (tQ[i]) begin
      modeTag = "R6"; op = tWr[i] ? 8'h61 : 8'h60; feat = tCnt[i];
      dev = tWr[i] ? 8'hC0 : 8'h40; lba = tLba[i]; cnt = 16'(tSlot[i]) * 16'd8;
    end else begin
      modeTag = "R5"; op = tWr[i] ? 8'h35 : 8'h25; feat = 0;
      dev = 8'h40; lba = tLba[i]; cnt = tCnt[i];
    end
    for (int k = 0; k < 20; k++) b[k] = 8'h00;                                // R7
    b[0] = 8'h27; b[1] = 8'h80 + {4'h0, tPmp[i]}; b[2] = op; b[3] = feat[7:0];
    for (int k = 0; k < 3; k++) begin
      b[4 + k] = lba[8*k +: 8];
      b[8 + k] = lba[24 + 8*k +: 8];
    end
    b[7] = dev; b[11] = feat[15:8]; b[12] = cnt[7:0]; b[13] = cnt[15:8];
    for (int w = 0; w < 5; w++) begin
      expQ.push_back({b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
      tagQ.push_back(w == 0 ? "R2 R3" : (w == 4 ? "R7" : modeTag));
    end
    return 1'b0;
  endfunction

  initial begin
    int          nextReq;
    int          cyc;
    logic [15:0] lfsr;
    setReq(0,  48'h0000_0123_4567, 16'd8,   0, 0, 5'd0,  4'd3,  1); // short read
    setReq(1,  48'h0000_0FFF_FFFF, 16'd256, 1, 0, 5'd0,  4'd0,  1); // short write, count 256
    setReq(2,  48'h0000_1000_0000, 16'd1,   0, 0, 5'd0,  4'd15, 1); // long by sector bit 28
    setReq(3,  48'h0000_0000_0005, 16'd257, 1, 0, 5'd0,  4'd1,  1); // long by count
    setReq(4,  48'hABCD_EF01_2345, 16'd300, 0, 1, 5'd31, 4'd2,  1); // queued read
    setReq(5,  48'h0000_0000_0040, 16'd16,  1, 1, 5'd7,  4'd0,  1); // queued write, FUA
    setReq(6,  48'h0000_1000_0000, 16'd1,   0, 0, 5'd0,  4'd0,  0); // refused: sector
    setReq(7,  48'h0000_0000_0010, 16'd4,   0, 1, 5'd3,  4'd0,  0); // refused: queued
    setReq(8,  48'h0000_0FFF_FFFF, 16'd256, 0, 0, 5'd0,  4'd9,  0); // short, no 48-bit support
    setReq(9,  48'h0000_0000_0001, 16'd257, 1, 0, 5'd0,  4'd0,  0); // refused: count
    setReq(10, 48'h0000_0000_0000, 16'd0,   0, 0, 5'd0,  4'd0,  1); // count 0
    setReq(11, 48'hFFFF_FFFF_FFFF, 16'hFFFF, 1, 0, 5'd0, 4'd4,  1); // extreme long write

    rstN = 0; reqValid = 0; wordReady = 0; reqLba = 0; reqCount = 0;
    reqWrite = 0; reqQueued = 0; reqSlot = 0; reqPmp = 0; devLong = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady === 1'b1, "R11 reqReady", 32'(reqReady), 32'd1);
    check(wordValid === 1'b0, "R11 wordValid", 32'(wordValid), 32'd0);
    check(errPulse === 1'b0, "R11 errPulse", 32'(errPulse), 32'd0);
    rstN = 1;

    nextReq = 0; cyc = 0; lfsr = 16'hACE1;
    while (nextReq < NREQ || busy || errPend) begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        check(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
        break;
      end
      // compare against model state
      check(reqReady === !busy, "R10 reqReady", 32'(reqReady), 32'(!busy));
      check(wordValid === busy, "R1 wordValid", 32'(wordValid), 32'(busy));
      check(errPulse === errPend, "R8 errPulse", 32'(errPulse), 32'(errPend));
      if (busy && expQ.size() > 0) begin
        check(wordData === expQ[0], stalledPrev ? {"R9 ", tagQ[0]} : tagQ[0], wordData, expQ[0]);
        check(wordLast === (expQ.size() == 1), "R10 wordLast", 32'(wordLast), 32'(expQ.size() == 1));
      end
      // next stimulus
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqValid  = (nextReq < NREQ) && lfsr[0];
      wordReady = lfsr[1] | lfsr[2];
      if (nextReq < NREQ) begin
        reqLba = tLba[nextReq]; reqCount = tCnt[nextReq]; reqWrite = tWr[nextReq];
        reqQueued = tQ[nextReq]; reqSlot = tSlot[nextReq]; reqPmp = tPmp[nextReq];
        devLong = tCap[nextReq];
      end
      // model update for the coming edge
      errPend = 0;
      stalledPrev = busy && !wordReady;
      if (reqValid && !busy) begin
        if (modelRequest(nextReq)) errPend = 1;
        else busy = 1;
        nextReq++;
      end else if (busy && wordReady) begin
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
        if (expQ.size() == 0) busy = 0;
      end
    end
    reqValid = 0;
    @(negedge clk);
    check(reqReady === 1'b1, "R1 ready at end", 32'(reqReady), 32'd1);
    check(wordValid === 1'b0, "R1 idle at end", 32'(wordValid), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule